// File: doc/BRIEF.md
# Framed Serial Word Transmitter

This block turns parallel words into a framed serial stream on three wires: a serial clock, a frame sync and a data line. It is always the clock master. A programmable divider derives the serial clock from the system clock. The block raises a one-period, active-high frame sync one serial clock before the first data bit of each word, which is the early-frame arrangement. Data leaves most significant bit first, and the word length can be set from 1 to `DATA_W` bits.

All outputs change on the serial clock edge opposite the one selected for sampling. A receiver set to the same sampling edge can therefore capture sync and data on the other edge. Words enter through a one-entry holding register with a ready/valid handshake. If the next word is waiting when the current word's last bit goes out, the new word's frame sync is raised on that same edge and the stream has no gap. If nothing is waiting, the block finishes the last bit's clock period, parks the clock at its idle level and raises an underflow flag.

Top module: `sertx_top`

## Requirements
- R1: After reset, `fsOut` and `txdOut` are 0, `underflow` is 0, `inReady` is 1, and `sclkOut` sits at its idle level.
- R2: While a transfer is active, every serial clock level lasts `cfgDiv`+1 system clocks, so one serial period is 2·(`cfgDiv`+1) system clocks.
- R3: With no transfer active, `sclkOut` rests at the idle level: low when `cfgRiseSample`=0 and high when `cfgRiseSample`=1. The first transition of a transfer is therefore a drive edge.
- R4: `fsOut` and `txdOut` change only in the system cycle where `sclkOut` makes its drive transition. That is a rising transition when `cfgRiseSample`=0 and a falling transition when `cfgRiseSample`=1.
- R5: `fsOut` is high for exactly one serial period per word. The first data bit, word bit `cfgLen`, is driven on the drive edge one serial period after the frame sync is raised.
- R6: A word carries the low `cfgLen`+1 bits of `inData`, sent MSB first. A receiver that samples on the non-drive edge recovers the word exactly.
- R7: If the next word is in the holding register at the last bit's drive edge, that word's frame sync rises on the same drive edge as the last bit.
- R8: If the holding register is empty at the last bit's drive edge, no frame sync is issued and `underflow` is set. `underflow` stays set until the next word is accepted. The clock completes the last bit's period and then stops at the idle level.
- R9: Between transfers `txdOut` keeps the value of the last bit sent, which is bit 0 of the previous word.
- R10: `inReady` is high exactly when the holding register is empty. A word is accepted in a cycle where `inValid` and `inReady` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgDiv | input | DIV_W | Divider setting N, serial period 2·(N+1) system clocks |
| cfgLen | input | LEN_W | Word length minus one |
| cfgRiseSample | input | 1 | 1: receiver samples on rising edge, block drives on falling |
| inData | input | DATA_W | Word to send, LSB-aligned |
| inValid | input | 1 | Word offered |
| inReady | output | 1 | Holding register empty |
| sclkOut | output | 1 | Serial clock |
| fsOut | output | 1 | Active-high early frame sync |
| txdOut | output | 1 | Serial data |
| underflow | output | 1 | Sticky: stream ran dry at a last bit |

## Verification
The risky overlap is the last data bit of one word and the frame sync of the next, which fall on the same drive edge in a continuous stream. The bench provokes it by loading the following word as soon as `inReady` returns, across both edge polarities, several divider settings and several word lengths. A bench receiver then samples the bus on the non-drive edge. It must finish the old word and open the new one at that single sample edge, with every decoded word equal to the value computed in the bench. The same receiver checks that a stream allowed to run dry issues no extra frame sync, leaves the clock idle and keeps the data line at the last bit.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,   // clock parked, waiting for a word
    ST_LEAD,   // clock running, frame sync goes out on next drive edge
    ST_WORD,   // bits being driven
    ST_TAIL    // last bit out, finishing its period
  } txState_e;

  // control -> datapath strobes, both aligned to a drive edge
  typedef struct packed {
    logic takeWord;  // move holding register into shifter
    logic shiftBit;  // drive next bit onto the data line
  } txStrobe_t;

endpackage

// File: rtl/sertx_dpath.sv
module sertx_dpath
  import sertx_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int LEN_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] inData,
  input  logic              inValid,
  input  logic [LEN_W-1:0]  cfgLen,
  input  txStrobe_t         strobes,
  output logic              inReady,
  output logic              holdFull,
  output logic              txdOut
);

  logic [DATA_W-1:0] holdReg;
  logic [DATA_W-1:0] shiftReg;
  logic              accept;

  assign inReady = !holdFull;
  assign accept  = inValid && inReady;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdReg  <= '0;
      holdFull <= 1'b0;
      shiftReg <= '0;
      txdOut   <= 1'b0;
    end else begin
      if (accept) begin
        holdReg  <= inData;
        holdFull <= 1'b1;
      end else if (strobes.takeWord) begin
        holdFull <= 1'b0;
      end
      if (strobes.shiftBit) begin
        txdOut <= shiftReg[cfgLen];
      end
      if (strobes.takeWord) begin
        shiftReg <= holdReg;
      end else if (strobes.shiftBit) begin
        shiftReg <= shiftReg << 1;
      end
    end
  end

  AST_TAKE_NEEDS_WORD: assert property (@(posedge clk) disable iff (!rstN)
    strobes.takeWord |-> holdFull) else $error("take from empty hold"); // R7

  AST_TXD_ON_SHIFT: assert property (@(posedge clk) disable iff (!rstN)
    (txdOut != $past(txdOut)) |-> $past(strobes.shiftBit)) else $error("txd moved without shift"); // R9

  AST_READY_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    $past(accept) |-> !inReady) else $error("ready after accept"); // R10

endmodule

// File: rtl/sertx_ctrl.sv
module sertx_ctrl
  import sertx_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] cfgDiv,
  input  logic [LEN_W-1:0] cfgLen,
  input  logic             cfgRiseSample,
  input  logic             holdFull,
  input  logic             accepted,
  output txStrobe_t        strobes,
  output logic             sclkOut,
  output logic             fsOut,
  output logic             underflow
);

  localparam int CNT_W = LEN_W + 1;

  txState_e         state;
  logic [DIV_W-1:0] divCnt;
  logic             sclkPhase;   // 0 = idle level, 0->1 is the drive edge
  logic [CNT_W-1:0] bitsLeft;
  logic             tick, driveEv, sampleEv, lastBit;
  logic [CNT_W-1:0] wordBits;

  assign wordBits = {1'b0, cfgLen} + 1'b1;
  assign tick     = (state != ST_IDLE) && (divCnt == cfgDiv);
  assign driveEv  = tick && !sclkPhase;
  assign sampleEv = tick && sclkPhase;
  assign lastBit  = (state == ST_WORD) && (bitsLeft == CNT_W'(1));
  assign sclkOut  = sclkPhase ^ cfgRiseSample;

  always_comb begin
    strobes.takeWord = driveEv && ((state == ST_LEAD) || (lastBit && holdFull));
    strobes.shiftBit = driveEv && (state == ST_WORD);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      divCnt    <= '0;
      sclkPhase <= 1'b0;
      fsOut     <= 1'b0;
      bitsLeft  <= '0;
      underflow <= 1'b0;
    end else begin
      if (accepted) underflow <= 1'b0;
      if (state == ST_IDLE) begin
        divCnt    <= '0;
        sclkPhase <= 1'b0;
        if (holdFull) state <= ST_LEAD;
      end else begin
        divCnt <= tick ? '0 : divCnt + 1'b1;
        if (tick) sclkPhase <= !sclkPhase;
      end
      case (state)
        ST_LEAD: if (driveEv) begin
          fsOut    <= 1'b1;
          bitsLeft <= wordBits;
          state    <= ST_WORD;
        end
        ST_WORD: if (driveEv) begin
          if (lastBit) begin
            if (holdFull) begin
              fsOut    <= 1'b1;
              bitsLeft <= wordBits;
            end else begin
              fsOut     <= 1'b0;
              underflow <= 1'b1;
              state     <= ST_TAIL;
            end
          end else begin
            fsOut    <= 1'b0;
            bitsLeft <= bitsLeft - 1'b1;
          end
        end
        ST_TAIL: if (sampleEv) state <= ST_IDLE;
        default: ;
      endcase
    end
  end

  AST_FS_ON_DRIVE: assert property (@(posedge clk) disable iff (!rstN)
    (fsOut != $past(fsOut)) |-> (sclkPhase && !$past(sclkPhase))) else $error("fs off drive edge"); // R4

  AST_DIV_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE) |-> (divCnt <= cfgDiv)) else $error("divider overrun"); // R2

  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> !sclkPhase) else $error("clock not parked"); // R3

  AST_UNDERFLOW_NO_FS: assert property (@(posedge clk) disable iff (!rstN)
    (underflow && !$past(underflow)) |-> !fsOut) else $error("fs with underflow"); // R8

endmodule

// File: rtl/sertx_top.sv
module sertx_top
  import sertx_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DIV_W  = 8,
  parameter int LEN_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DIV_W-1:0]  cfgDiv,
  input  logic [LEN_W-1:0]  cfgLen,
  input  logic              cfgRiseSample,
  input  logic [DATA_W-1:0] inData,
  input  logic              inValid,
  output logic              inReady,
  output logic              sclkOut,
  output logic              fsOut,
  output logic              txdOut,
  output logic              underflow
);

  txStrobe_t strobes;
  logic      holdFull;
  logic      accepted;

  assign accepted = inValid && inReady;

  sertx_ctrl #(.DIV_W(DIV_W), .LEN_W(LEN_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .cfgDiv(cfgDiv), .cfgLen(cfgLen),
    .cfgRiseSample(cfgRiseSample), .holdFull(holdFull), .accepted(accepted),
    .strobes(strobes), .sclkOut(sclkOut), .fsOut(fsOut), .underflow(underflow)
  );

  sertx_dpath #(.DATA_W(DATA_W), .LEN_W(LEN_W)) i_dpath (
    .clk(clk), .rstN(rstN), .inData(inData), .inValid(inValid), .cfgLen(cfgLen),
    .strobes(strobes), .inReady(inReady), .holdFull(holdFull), .txdOut(txdOut)
  );

endmodule

// File: tb/test_sertx_top.sv
module test_sertx_top;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 16;
  localparam int DIV_W  = 8;
  localparam int LEN_W  = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [DIV_W-1:0] cfgDiv = '0;
  logic [LEN_W-1:0] cfgLen = '0;
  logic cfgRiseSample = 1'b0;
  logic [DATA_W-1:0] inData = '0;
  logic inValid = 1'b0;
  logic inReady, sclkOut, fsOut, txdOut, underflow;

  sertx_top #(.DATA_W(DATA_W), .DIV_W(DIV_W), .LEN_W(LEN_W)) i_sertx_top (
    .clk(clk), .rstN(rstN), .cfgDiv(cfgDiv), .cfgLen(cfgLen),
    .cfgRiseSample(cfgRiseSample), .inData(inData), .inValid(inValid),
    .inReady(inReady), .sclkOut(sclkOut), .fsOut(fsOut), .txdOut(txdOut),
    .underflow(underflow)
  );

  always #(CLK_PERIOD/2) clk = !clk;

  int total = 0, bad = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
    end
  endtask

  // bench receiver state
  logic [DATA_W-1:0] expWord [0:7];
  int  nSent = 0, rxIdx = 0, rxCnt = 0, overlapCnt = 0, transCnt = 0, halfCnt = 0;
  logic [DATA_W-1:0] rxWord = '0;
  bit  rxOn = 0, monOn = 0, pSampFs = 0;
  logic pSclk = 0, pFs = 0, pTxd = 0;

  function automatic logic idleLvl();
    return cfgRiseSample;
  endfunction

  always @(negedge clk) begin
    if (monOn) begin
      halfCnt++;
      if ((fsOut != pFs) || (txdOut != pTxd))
        check((sclkOut != pSclk) && (sclkOut != idleLvl()), "R4", int'(sclkOut), int'(!idleLvl()));
      if (sclkOut != pSclk) begin
        if (sclkOut == idleLvl()) begin
          check(halfCnt == int'(cfgDiv) + 1, "R2", halfCnt, int'(cfgDiv) + 1);
          if (rxOn) begin
            rxWord = {rxWord[DATA_W-2:0], txdOut};
            rxCnt++;
            if (rxCnt == int'(cfgLen) + 1) begin
              check(rxWord == expWord[rxIdx], "R6", int'(rxWord), int'(expWord[rxIdx]));
              rxIdx++;
              rxOn = 0;
              if (fsOut) overlapCnt++;
            end
          end
          if (fsOut) begin
            check(!pSampFs, "R5", 1, 0);
            check(!rxOn, "R5", rxCnt, int'(cfgLen) + 1);
            rxOn = 1; rxCnt = 0; rxWord = '0;
          end
          pSampFs = fsOut;
        end
        halfCnt = 0;
        transCnt++;
      end
    end
    pSclk = sclkOut; pFs = fsOut; pTxd = txdOut;
  end

  task automatic sendWord(input logic [DATA_W-1:0] w);
    @(negedge clk);
    inData = w; inValid = 1'b1;
    while (!inReady) @(negedge clk);
    @(negedge clk);
    inValid = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      check(0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int cfgIdx = 0;
    for (int edgeSel = 0; edgeSel < 2; edgeSel++) begin
      for (int d = 0; d < 3; d++) begin
        for (int l = 0; l < 3; l++) begin
          int bits;
          int cnt0;
          logic [DATA_W-1:0] mask;
          bits = (l == 0) ? 4 : (l == 1) ? 8 : 16;
          mask = (bits == 16) ? 16'hFFFF : DATA_W'((1 << bits) - 1);
          monOn = 0;
          @(negedge clk);
          rstN = 1'b0;
          cfgRiseSample = edgeSel[0];
          cfgDiv = DIV_W'((d == 2) ? 3 : d);
          cfgLen = LEN_W'(bits - 1);
          repeat (3) @(negedge clk);
          rstN = 1'b1;
          @(negedge clk);
          // R1 reset state
          check(sclkOut == idleLvl(), "R1", int'(sclkOut), int'(idleLvl()));
          check(!fsOut && !txdOut && !underflow, "R1", int'({fsOut, txdOut, underflow}), 0);
          check(inReady, "R1", int'(inReady), 1);
          nSent = 0; rxIdx = 0; rxCnt = 0; overlapCnt = 0; transCnt = 0; halfCnt = 0;
          rxOn = 0; pSampFs = 0;
          pSclk = sclkOut; pFs = fsOut; pTxd = txdOut;
          monOn = 1;
          for (int k = 0; k < 4; k++)
            expWord[k] = DATA_W'(k * 16'h9E37 + cfgIdx * 16'h1235 + 16'h5A) & mask;
          // continuous stream of three words
          for (int k = 0; k < 3; k++) begin
            sendWord(expWord[k]);
            nSent++;
          end
          while (rxIdx < 3) @(negedge clk);
          repeat (2 * (int'(cfgDiv) + 1) + 4) @(negedge clk);
          check(overlapCnt == 2, "R7", overlapCnt, 2);
          check(underflow == 1'b1, "R8", int'(underflow), 1);
          check(sclkOut == idleLvl(), "R3", int'(sclkOut), int'(idleLvl()));
          check(txdOut == expWord[2][0], "R9", int'(txdOut), int'(expWord[2][0]));
          check(inReady, "R10", int'(inReady), 1);
          cnt0 = transCnt;
          repeat (20) @(negedge clk);
          check(transCnt == cnt0, "R8", transCnt, cnt0);
          check(txdOut == expWord[2][0], "R9", int'(txdOut), int'(expWord[2][0]));
          // single isolated word after a gap
          sendWord(expWord[3]);
          nSent++;
          check(!underflow, "R8", int'(underflow), 0);
          while (rxIdx < 4) @(negedge clk);
          repeat (2 * (int'(cfgDiv) + 1) + 4) @(negedge clk);
          check(overlapCnt == 2, "R8", overlapCnt, 2);
          check(underflow == 1'b1, "R8", int'(underflow), 1);
          check(sclkOut == idleLvl(), "R3", int'(sclkOut), int'(idleLvl()));
          check(txdOut == expWord[3][0], "R9", int'(txdOut), int'(expWord[3][0]));
          check(rxIdx == nSent, "R6", rxIdx, nSent);
          cfgIdx++;
        end
      end
    end
    monOn = 0;
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule